// File: doc/BRIEF.md
# I2C Register-Bank Target

This block is an I2C target that lets a bus host read and write a bank of 8-bit registers kept outside the block. It watches open-drain SCL and SDA through a plain input per line, and pulls SDA low through an output-enable whose data value is always zero. SCL is never driven. Each line passes through a synchronizer and a glitch filter before START, STOP and clock edges are detected.

A write transfer addresses the device, and its first data byte loads an 8-bit register pointer. Each later byte is stored at the pointer, and the pointer then steps up by one. A read transfer, usually reached through a repeated START after the pointer is set, returns the register at the pointer. It keeps returning bytes from rising addresses as long as the host acknowledges them. On the register side there is a synchronous port with address, write data, a one-cycle write strobe and a read-data input. Read data must be valid one clock after the address is presented.

Top module: `i2c_regbank_target`

## Requirements
- R1: An address byte whose upper seven bits equal the device address (default 7'b0100001, so 0x42 to write and 0x43 to read, with the R/W flag in bit 0) is acknowledged: SDA is held low during the ninth clock.
- R2: After an address byte that does not match, SDA stays released and no register write takes place until the next START or STOP.
- R3: The first byte after a write-direction address loads the register pointer and is acknowledged. It produces no register write.
- R4: Each further write byte, received MSB first, gives exactly one single-cycle write strobe with the address equal to the pointer and the data equal to the byte. The byte is acknowledged, and the pointer then steps up by one.
- R5: After a read-direction address, the block sends the register at the pointer MSB first and steps the pointer by one per byte. The pointer keeps its value across a repeated START and between transfers.
- R6: A host ACK (SDA low in the ninth clock) after a read byte starts the next byte. A host NACK makes the block release SDA and stay silent until the next START.
- R7: A START or STOP in the middle of a byte abandons that byte with no register write. After a START, the block matches an address again.
- R8: The register pointer is 8 bits wide and wraps from 0xFF to 0x00, on writes and on reads.
- R9: A pulse on SDA or SCL that lasts fewer than FILT_LEN system clocks (default 3) is ignored. It neither ends a transfer nor corrupts the byte being received.
- R10: The block begins pulling SDA low only while SCL is low, and its SDA output value is always 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| scl_i | input | 1 | Sensed SCL line level |
| sda_i | input | 1 | Sensed SDA line level |
| sda_o | output | 1 | SDA output value, always 0 |
| sda_oe | output | 1 | Pull SDA low when 1 |
| reg_addr | output | 8 | Register address, equal to the pointer |
| reg_wdata | output | 8 | Register write data |
| reg_we | output | 1 | Single-cycle register write strobe |
| reg_rdata | input | 8 | Register read data for reg_addr |

## Verification
Random bursts of random length are written at random pointers and then read back through a repeated START. The read-back shows whether each byte landed at its own address. A read that follows with no pointer byte shows whether the pointer survives between transfers. A directed burst starting at 0xFD separates correct 8-bit wrapping from overflow into a ninth bit. A foreign address followed by data bytes separates a target that stays silent from one that acts on traffic meant for another device. A START inserted after four data bits, and a two-clock SDA pulse while SCL is high, separate correct abort handling from correct filtering.

// File: rtl/i2c_tgt_pkg.sv
package i2c_tgt_pkg;

    localparam int BYTE_W = 8;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_SACK,
        ST_RX,
        ST_TX,
        ST_MACK
    } tgt_st_e;

    typedef struct packed {
        tgt_st_e           st;
        logic [BYTE_W-1:0] sh;
        logic [3:0]        cnt;
        logic [BYTE_W-1:0] ptr;
        logic              sda_low;
        logic              rd;
        logic              have_ptr;
        logic              mack;
        logic              we;
        logic [BYTE_W-1:0] wdata;
    } tgt_state_t;

endpackage

// File: rtl/i2c_line_filter.sv
module i2c_line_filter #(
    parameter int SYNC_STAGES = 2,
    parameter int FILT_LEN    = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic line_i,
    output logic line_o
);
    localparam int CW  = $clog2(FILT_LEN + 1);
    localparam int TOP = SYNC_STAGES - 1;

    typedef struct packed {
        logic [SYNC_STAGES-1:0] sync;
        logic [CW-1:0]          cnt;
        logic                   out;
    } flt_t;

    flt_t q, d;

    always_comb begin
        d      = q;
        d.sync = {q.sync[TOP-1:0], line_i};
        if (q.sync[TOP] != q.out) begin
            if (q.cnt == CW'(FILT_LEN - 1)) begin
                d.out = q.sync[TOP];
                d.cnt = '0;
            end else begin
                d.cnt = q.cnt + CW'(1);
            end
        end else begin
            d.cnt = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '{sync: '1, cnt: '0, out: 1'b1};
        else        q <= d;
    end

    assign line_o = q.out;
endmodule

// File: rtl/i2c_bus_events.sv
module i2c_bus_events (
    input  logic clk,
    input  logic rst_n,
    input  logic scl,
    input  logic sda,
    output logic start_o,
    output logic stop_o,
    output logic rise_o,
    output logic fall_o
);
    typedef struct packed {
        logic scl;
        logic sda;
    } prev_t;

    prev_t q, d;

    always_comb begin
        d.scl = scl;
        d.sda = sda;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '{scl: 1'b1, sda: 1'b1};
        else        q <= d;
    end

    assign start_o = scl & q.scl & q.sda & ~sda;
    assign stop_o  = scl & q.scl & ~q.sda & sda;
    assign rise_o  = scl & ~q.scl;
    assign fall_o  = ~scl & q.scl;
endmodule

// File: rtl/i2c_target_fsm.sv
module i2c_target_fsm
    import i2c_tgt_pkg::*;
#(
    parameter logic [6:0] DEV_ADDR = 7'h21
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic              stop_i,
    input  logic              rise_i,
    input  logic              fall_i,
    input  logic              sda_i,
    input  logic [BYTE_W-1:0] rdata_i,
    output logic              sda_low_o,
    output logic [BYTE_W-1:0] addr_o,
    output logic [BYTE_W-1:0] wdata_o,
    output logic              we_o,
    output logic              idle_o
);
    localparam logic [3:0] LAST_BIT = 4'(BYTE_W);

    tgt_state_t q, d;

    always_comb begin
        d    = q;
        d.we = 1'b0;
        if (q.we) d.ptr = q.ptr + 8'd1;
        if (start_i) begin
            d.st      = ST_ADDR;
            d.cnt     = '0;
            d.sda_low = 1'b0;
        end else if (stop_i) begin
            d.st      = ST_IDLE;
            d.sda_low = 1'b0;
        end else begin
            unique case (q.st)
                ST_ADDR, ST_RX: begin
                    if (rise_i) begin
                        d.sh  = {q.sh[BYTE_W-2:0], sda_i};
                        d.cnt = q.cnt + 4'd1;
                    end
                    if (fall_i && q.cnt == LAST_BIT) begin
                        if (q.st == ST_ADDR) begin
                            if (q.sh[7:1] == DEV_ADDR) begin
                                d.rd       = q.sh[0];
                                d.have_ptr = 1'b0;
                                d.sda_low  = 1'b1;
                                d.st       = ST_SACK;
                            end else begin
                                d.st = ST_IDLE;
                            end
                        end else begin
                            if (!q.have_ptr) begin
                                d.ptr      = q.sh;
                                d.have_ptr = 1'b1;
                            end else begin
                                d.we    = 1'b1;
                                d.wdata = q.sh;
                            end
                            d.sda_low = 1'b1;
                            d.st      = ST_SACK;
                        end
                    end
                end
                ST_SACK: begin
                    if (fall_i) begin
                        d.cnt = '0;
                        if (q.rd) begin
                            d.sh      = rdata_i;
                            d.sda_low = ~rdata_i[7];
                            d.st      = ST_TX;
                        end else begin
                            d.sda_low = 1'b0;
                            d.st      = ST_RX;
                        end
                    end
                end
                ST_TX: begin
                    if (rise_i) d.cnt = q.cnt + 4'd1;
                    if (fall_i) begin
                        if (q.cnt == LAST_BIT) begin
                            d.sda_low = 1'b0;
                            d.mack    = 1'b0;
                            d.ptr     = q.ptr + 8'd1;
                            d.st      = ST_MACK;
                        end else begin
                            d.sh      = {q.sh[BYTE_W-2:0], 1'b0};
                            d.sda_low = ~q.sh[6];
                        end
                    end
                end
                ST_MACK: begin
                    if (rise_i) d.mack = ~sda_i;
                    if (fall_i) begin
                        if (q.mack) begin
                            d.sh      = rdata_i;
                            d.sda_low = ~rdata_i[7];
                            d.cnt     = '0;
                            d.st      = ST_TX;
                        end else begin
                            d.st = ST_IDLE;
                        end
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '{st: ST_IDLE, default: '0};
        else        q <= d;
    end

    assign sda_low_o = q.sda_low;
    assign addr_o    = q.ptr;
    assign wdata_o   = q.wdata;
    assign we_o      = q.we;
    assign idle_o    = (q.st == ST_IDLE);
endmodule

// File: rtl/i2c_regbank_target.sv
module i2c_regbank_target
    import i2c_tgt_pkg::*;
#(
    parameter logic [6:0] DEV_ADDR    = 7'h21,
    parameter int         SYNC_STAGES = 2,
    parameter int         FILT_LEN    = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_i,
    input  logic              sda_i,
    output logic              sda_o,
    output logic              sda_oe,
    output logic [BYTE_W-1:0] reg_addr,
    output logic [BYTE_W-1:0] reg_wdata,
    output logic              reg_we,
    input  logic [BYTE_W-1:0] reg_rdata
);
    localparam int N_LINES = 2;

    logic [N_LINES-1:0] raw_lines;
    logic [N_LINES-1:0] clean_lines;
    logic start_ev, stop_ev, rise_ev, fall_ev;
    logic bus_idle;

    assign raw_lines = {scl_i, sda_i};

    for (genvar g = 0; g < N_LINES; g++) begin : g_line
        i2c_line_filter #(
            .SYNC_STAGES(SYNC_STAGES),
            .FILT_LEN   (FILT_LEN)
        ) u_filt (
            .clk   (clk),
            .rst_n (rst_n),
            .line_i(raw_lines[g]),
            .line_o(clean_lines[g])
        );
    end

    i2c_bus_events u_events (
        .clk    (clk),
        .rst_n  (rst_n),
        .scl    (clean_lines[1]),
        .sda    (clean_lines[0]),
        .start_o(start_ev),
        .stop_o (stop_ev),
        .rise_o (rise_ev),
        .fall_o (fall_ev)
    );

    i2c_target_fsm #(
        .DEV_ADDR(DEV_ADDR)
    ) u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .start_i  (start_ev),
        .stop_i   (stop_ev),
        .rise_i   (rise_ev),
        .fall_i   (fall_ev),
        .sda_i    (clean_lines[0]),
        .rdata_i  (reg_rdata),
        .sda_low_o(sda_oe),
        .addr_o   (reg_addr),
        .wdata_o  (reg_wdata),
        .we_o     (reg_we),
        .idle_o   (bus_idle)
    );

    assign sda_o = 1'b0;
endmodule

// File: rtl/i2c_regbank_target_chk.sv
module i2c_regbank_target_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       scl_i,
    input logic       sda_o,
    input logic       sda_oe,
    input logic       reg_we,
    input logic [7:0] reg_addr,
    input logic       bus_idle
);
    AST_DRIVE_ONLY_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sda_oe) |-> !scl_i); // R10

    AST_OUT_VALUE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        sda_oe |-> !sda_o); // R10

    AST_WE_SINGLE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        reg_we |=> !reg_we); // R4

    AST_PTR_STEP_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        reg_we |=> reg_addr == 8'($past(reg_addr) + 8'd1)); // R8

    AST_IDLE_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        bus_idle |-> (!sda_oe && !reg_we)); // R2
endmodule

bind i2c_regbank_target i2c_regbank_target_chk u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .scl_i   (scl_i),
    .sda_o   (sda_o),
    .sda_oe  (sda_oe),
    .reg_we  (reg_we),
    .reg_addr(reg_addr),
    .bus_idle(bus_idle)
);

// File: tb/test_i2c_regbank_target.sv
`timescale 1ns/1ps
module test_i2c_regbank_target;
    localparam int Q = 10;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic scl_m = 1'b1;
    logic sda_m = 1'b1;
    logic glitch = 1'b0;
    logic sda_o, sda_oe, reg_we;
    logic [7:0] reg_addr, reg_wdata, reg_rdata;
    logic sda_line;

    logic [7:0] mem [256];
    logic [7:0] exp_mem [256];
    logic [7:0] wbuf [16];
    int we_cnt = 0;
    int n_chk = 0;
    int n_bad = 0;

    always #2.5 clk = ~clk;

    assign sda_line = sda_m & ~glitch & ~sda_oe;

    i2c_regbank_target i_i2c_regbank_target (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_line),
        .sda_o(sda_o), .sda_oe(sda_oe), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_we(reg_we), .reg_rdata(reg_rdata)
    );

    always_comb reg_rdata = mem[reg_addr];

    always_ff @(posedge clk) begin
        if (reg_we) begin
            mem[reg_addr] <= reg_wdata;
            we_cnt <= we_cnt + 1;
        end
    end

    function automatic logic [7:0] nxt(input logic [7:0] a, input int k);
        return 8'(a + 8'(k));
    endfunction

    function automatic logic [7:0] want(input logic [7:0] p, input int k);
        return exp_mem[nxt(p, k)];
    endfunction

    task automatic chk(input logic ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic wq(input int k);
        repeat (k) @(negedge clk);
    endtask

    task automatic bit_w(input logic b, input logic g);
        sda_m = b; wq(Q);
        scl_m = 1'b1; wq(Q);
        if (g) begin glitch = 1'b1; wq(2); glitch = 1'b0; wq(Q - 2); end
        else wq(Q);
        scl_m = 1'b0; wq(Q);
    endtask

    task automatic bit_r(output logic b);
        sda_m = 1'b1; wq(Q);
        scl_m = 1'b1; wq(Q);
        b = sda_line; wq(Q);
        scl_m = 1'b0; wq(Q);
    endtask

    task automatic bus_start();
        sda_m = 1'b1; wq(Q);
        scl_m = 1'b1; wq(Q);
        sda_m = 1'b0; wq(Q);
        scl_m = 1'b0; wq(Q);
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; wq(Q);
        scl_m = 1'b1; wq(Q);
        sda_m = 1'b1; wq(2 * Q);
    endtask

    task automatic wr_byte(input logic [7:0] v, input logic g, output logic ack);
        logic b;
        for (int i = 7; i >= 0; i--) bit_w(v[i], g && i == 7);
        bit_r(b);
        ack = ~b;
    endtask

    task automatic rd_byte(input logic ack_m, output logic [7:0] v);
        logic b;
        for (int i = 7; i >= 0; i--) begin bit_r(b); v[i] = b; end
        bit_w(~ack_m, 1'b0);
    endtask

    task automatic do_write(input logic [7:0] p, input int n, input logic g);
        logic a;
        int w0;
        w0 = we_cnt;
        bus_start();
        wr_byte(8'h42, 1'b0, a); chk(a, "R1 write address ack", a, 1);
        wr_byte(p, 1'b0, a);     chk(a, "R3 pointer ack", a, 1);
        for (int i = 0; i < n; i++) begin
            wr_byte(wbuf[i], g && i == 0, a);
            chk(a, g ? "R9 filtered byte ack" : "R4 data ack", a, 1);
            exp_mem[nxt(p, i)] = wbuf[i];
        end
        bus_stop();
        chk(we_cnt - w0 == n, "R3 R4 write strobe count", we_cnt - w0, n);
    endtask

    task automatic read_tail(input logic [7:0] p, input int n, input string tag);
        logic [7:0] v;
        for (int i = 0; i < n; i++) begin
            rd_byte(i < n - 1, v);
            chk(v == want(p, i), tag, v, want(p, i));
        end
        for (int i = 0; i < 2 * Q; i++) begin
            if (sda_oe) begin chk(1'b0, "R6 SDA released after NACK", 1, 0); break; end
            wq(1);
        end
        n_chk++;
        bus_stop();
    endtask

    task automatic do_read(input logic [7:0] p, input int n);
        logic a;
        bus_start();
        wr_byte(8'h42, 1'b0, a); chk(a, "R1 address ack", a, 1);
        wr_byte(p, 1'b0, a);     chk(a, "R3 pointer ack", a, 1);
        bus_start();
        wr_byte(8'h43, 1'b0, a); chk(a, "R1 read address ack", a, 1);
        read_tail(p, n, "R5 R8 read data");
    endtask

    initial begin
        logic a;
        logic [7:0] p;
        int n;
        int unsigned seed;
        seed = $urandom(32'h1C2A);
        for (int i = 0; i < 256; i++) begin
            mem[i] = 8'($urandom);
            exp_mem[i] = mem[i];
        end
        wq(10);
        chk(sda_oe == 1'b0 && reg_we == 1'b0, "R10 reset released", sda_oe, 0);
        rst_n = 1'b1;
        wq(10);

        wbuf[0] = 8'h3C;
        do_write(8'h07, 1, 1'b0);
        do_read(8'h07, 1);

        for (int t = 0; t < 8; t++) begin
            p = 8'($urandom);
            n = 1 + int'($urandom_range(5));
            for (int i = 0; i < n; i++) wbuf[i] = 8'($urandom);
            do_write(p, n, 1'b0);
            do_read(p, n);
        end

        for (int i = 0; i < 5; i++) wbuf[i] = 8'hB0 + 8'(i);
        do_write(8'hFD, 5, 1'b0);
        do_read(8'hFD, 5);
        bus_start();
        wr_byte(8'h43, 1'b0, a); chk(a, "R5 read without pointer ack", a, 1);
        read_tail(8'h02, 2, "R5 pointer kept between transfers");

        n = we_cnt;
        bus_start();
        wr_byte(8'h44, 1'b0, a); chk(!a, "R2 foreign address no ack", a, 0);
        wr_byte(8'h30, 1'b0, a); chk(!a, "R2 ignored byte no ack", a, 0);
        wr_byte(8'h99, 1'b0, a); chk(!a, "R2 ignored byte no ack", a, 0);
        bus_stop();
        chk(we_cnt == n, "R2 no write on foreign address", we_cnt - n, 0);
        do_read(8'h30, 1);

        n = we_cnt;
        bus_start();
        wr_byte(8'h42, 1'b0, a);
        wr_byte(8'h10, 1'b0, a);
        for (int i = 0; i < 4; i++) bit_w(1'b1, 1'b0);
        bus_start();
        wr_byte(8'h42, 1'b0, a); chk(a, "R7 address after abort", a, 1);
        wr_byte(8'h20, 1'b0, a);
        wr_byte(8'hA5, 1'b0, a);
        bus_stop();
        exp_mem[8'h20] = 8'hA5;
        chk(we_cnt - n == 1, "R7 aborted byte not written", we_cnt - n, 1);
        do_read(8'h10, 1);
        do_read(8'h20, 1);

        wbuf[0] = 8'hC3;
        wbuf[1] = 8'h5A;
        do_write(8'h55, 2, 1'b1);
        do_read(8'h55, 2);

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule